// File: doc/BRIEF.md
# Dual-Clock Presettable Up/Down Counter

This block is a four-bit counter with two count inputs: one clock that steps the value up and one that steps it down. A parameter fixes the counting range at build time, either decimal (0 to 9) or full binary (0 to 15). A master clear forces the value to zero and wins over everything else. An active-low load copies a four-bit preset into the counter without waiting for either count clock.

Two active-low terminal outputs mark the ends of the range. The carry output is low while the count sits at its maximum and the up clock is low. The borrow output is low while the count is zero and the down clock is low. Each of these outputs therefore gives a pulse that ends exactly when the count wraps. Wiring carry and borrow of one counter to the up and down clocks of the next builds wider counters.

Both count clocks are treated as ordinary signals. A free-running system clock samples them through a synchronizer, and each step happens on a detected rising edge. In decimal mode a counter that holds 10 to 15 after a preset rejoins the legal range on its next step.

Top module: `dual_clk_updown_ctr`

## Requirements
- R1: A system reset, or a high `master_clear`, leaves the count at 0 after the next system clock edge. `master_clear` takes priority over `load_n`.
- R2: While `load_n` is low and `master_clear` is low, each system clock edge copies `preset` into the count. This happens whatever the count clocks do.
- R3: A rising edge on `up_clk` while `dn_clk` stays high adds one to the count. The new value appears on the third system clock edge after the input rises.
- R4: A rising edge on `dn_clk` while `up_clk` stays high subtracts one from the count, with the same latency as R3.
- R5: The maximum is 9 when `DECADE`=1 and 15 when `DECADE`=0. Stepping up from the maximum gives 0, and stepping down from 0 gives the maximum.
- R6: With `DECADE`=1, an up step from any value from 10 to 15 gives 0, and a down step from any of those values gives 9.
- R7: `carry_n` is low exactly when the count equals the maximum and the synchronized up clock is low. It returns high in the same cycle that the count becomes 0.
- R8: `borrow_n` is low exactly when the count is 0 and the synchronized down clock is low. It returns high in the same cycle that the count becomes the maximum.
- R9: No step occurs when both count clocks rise in the same system cycle. No step occurs when one count clock rises while the other is low.
- R10: Count-clock edges that arrive while load or clear is active have no effect. An edge detected in the first system cycle after load and clear are both released is also dropped.
- R11: Two `DECADE`=1 counters chained through carry and borrow count from 00 to 99 as a two-digit value. They wrap from 99 to 00 going up and from 00 to 99 going down.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples every other input |
| rst | input | 1 | Synchronous active-high system reset |
| master_clear | input | 1 | Active-high clear to zero; overrides all other inputs |
| load_n | input | 1 | Active-low parallel load of `preset` |
| preset | input | 4 | Value taken on load |
| up_clk | input | 1 | Count-up clock; a rising edge steps the count up |
| dn_clk | input | 1 | Count-down clock; a rising edge steps the count down |
| count | output | 4 | Current count |
| carry_n | output | 1 | Active-low terminal count for the up direction |
| borrow_n | output | 1 | Active-low terminal count for the down direction |

## Verification
A wrong count register shows at `count` and at the chained upper digit. The upper digit is affected the next time the lower digit passes its maximum or zero, because carry and borrow are decoded from the stored value. A bad edge detector or gating state either drops or adds a step. This shows up within three system cycles of the offending count-clock edge, so checking the two-digit value after every pulse localises it. A wrong terminal decode shows up during the low phase of the next pulse that reaches 9, 15 or 0. A wrong terminal decode also shows up in the cycle of the wrap itself, where the output must return high together with the new count.

// File: rtl/ductr_pkg.sv
package ductr_pkg;

    localparam int CW = 4;

    typedef logic [CW-1:0] cnt_t;

    typedef enum logic [2:0] {
        STEP_NONE  = 3'd0,
        STEP_UP    = 3'd1,
        STEP_DOWN  = 3'd2,
        STEP_LOAD  = 3'd3,
        STEP_CLEAR = 3'd4
    } step_e;

    typedef struct packed {
        logic lvl;        // synchronized level aligned with the count register
        logic rise;       // one-cycle rising edge indication
        logic steady_hi;  // high now and high in the previous sample
    } edge_t;

    function automatic cnt_t max_of(input logic decade);
        return decade ? cnt_t'(9) : cnt_t'((1 << CW) - 1);
    endfunction

    function automatic cnt_t next_up(input cnt_t c, input cnt_t top);
        if (c >= top) return '0;
        return cnt_t'(c + 1'b1);
    endfunction

    function automatic cnt_t next_down(input cnt_t c, input cnt_t top);
        if (c == '0 || c > top) return top;
        return cnt_t'(c - 1'b1);
    endfunction

endpackage

// File: rtl/ductr_edge_sync.sv
module ductr_edge_sync
    import ductr_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  din,
    output edge_t ev
);

    logic [STAGES-1:0] chain;
    logic              prev_q;
    logic              cur;

    assign cur = chain[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            chain  <= '1;
            prev_q <= 1'b1;
        end else begin
            chain  <= {chain[STAGES-2:0], din};
            prev_q <= cur;
        end
    end

    assign ev.lvl       = prev_q;
    assign ev.rise      = cur & ~prev_q;
    assign ev.steady_hi = cur & prev_q;

    // R3: an edge indication lasts exactly one system cycle
    property p_rise_once;
        @(posedge clk) disable iff (rst) ev.rise |=> !ev.rise;
    endproperty
    assert_rise_once_R3: assert property (p_rise_once);

endmodule

// File: rtl/ductr_step_ctl.sv
module ductr_step_ctl
    import ductr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  master_clear,
    input  logic  load_n,
    input  edge_t up_ev,
    input  edge_t dn_ev,
    output step_e step
);

    logic hold_q;

    always_ff @(posedge clk) begin
        if (rst) hold_q <= 1'b1;
        else     hold_q <= master_clear | ~load_n;
    end

    always_comb begin
        if (master_clear)                       step = STEP_CLEAR;
        else if (!load_n)                       step = STEP_LOAD;
        else if (hold_q)                        step = STEP_NONE;
        else if (up_ev.rise && dn_ev.steady_hi) step = STEP_UP;
        else if (dn_ev.rise && up_ev.steady_hi) step = STEP_DOWN;
        else                                    step = STEP_NONE;
    end

    // R9: the two counting directions never fire together
    property p_one_dir;
        @(posedge clk) disable iff (rst)
            !(step == STEP_UP && dn_ev.rise) && !(step == STEP_DOWN && up_ev.rise);
    endproperty
    assert_one_direction_R9: assert property (p_one_dir);

endmodule

// File: rtl/dual_clk_updown_ctr.sv
module dual_clk_updown_ctr
    import ductr_pkg::*;
#(
    parameter bit DECADE      = 1'b1,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          master_clear,
    input  logic          load_n,
    input  logic [CW-1:0] preset,
    input  logic          up_clk,
    input  logic          dn_clk,
    output logic [CW-1:0] count,
    output logic          carry_n,
    output logic          borrow_n
);

    localparam cnt_t CMAX  = max_of(DECADE);
    localparam int   NCHAN = 2;
    localparam int   CH_UP = 0;
    localparam int   CH_DN = 1;

    logic [NCHAN-1:0] raw;
    edge_t            ev [NCHAN];
    step_e            step;
    cnt_t             count_q;

    assign raw[CH_UP] = up_clk;
    assign raw[CH_DN] = dn_clk;

    for (genvar g = 0; g < NCHAN; g++) begin : g_chan
        ductr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk (clk),
            .rst (rst),
            .din (raw[g]),
            .ev  (ev[g])
        );
    end

    ductr_step_ctl u_ctl (
        .clk          (clk),
        .rst          (rst),
        .master_clear (master_clear),
        .load_n       (load_n),
        .up_ev        (ev[CH_UP]),
        .dn_ev        (ev[CH_DN]),
        .step         (step)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else begin
            unique case (step)
                STEP_CLEAR: count_q <= '0;
                STEP_LOAD:  count_q <= preset;
                STEP_UP:    count_q <= next_up(count_q, CMAX);
                STEP_DOWN:  count_q <= next_down(count_q, CMAX);
                default:    count_q <= count_q;
            endcase
        end
    end

    assign count    = count_q;
    assign carry_n  = ~((count_q == CMAX) & ~ev[CH_UP].lvl);
    assign borrow_n = ~((count_q == '0)   & ~ev[CH_DN].lvl);

    property p_clear;
        @(posedge clk) disable iff (rst) master_clear |=> (count_q == '0);
    endproperty
    assert_clear_zero_R1: assert property (p_clear);

    property p_load;
        @(posedge clk) disable iff (rst)
            (!master_clear && !load_n) |=> (count_q == $past(preset));
    endproperty
    assert_load_value_R2: assert property (p_load);

    property p_legal_after_step;
        @(posedge clk) disable iff (rst)
            (step == STEP_UP || step == STEP_DOWN) |=> (count_q <= CMAX);
    endproperty
    assert_legal_after_step_R6: assert property (p_legal_after_step);

    property p_carry;
        @(posedge clk) disable iff (rst) !carry_n |-> (count_q == CMAX);
    endproperty
    assert_carry_at_max_R7: assert property (p_carry);

    property p_borrow;
        @(posedge clk) disable iff (rst) !borrow_n |-> (count_q == '0);
    endproperty
    assert_borrow_at_zero_R8: assert property (p_borrow);

    property p_release_drop;
        @(posedge clk) disable iff (rst)
            ($past(master_clear || !load_n) && !master_clear && load_n)
                |=> (count_q == $past(count_q));
    endproperty
    assert_release_drop_R10: assert property (p_release_drop);

endmodule

// File: tb/dual_clk_updown_ctr_bench.sv
module dual_clk_updown_ctr_bench;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst = 1'b1, mclr = 1'b0, ld_n = 1'b1, up_in = 1'b1, dn_in = 1'b1;
    logic [3:0] pre_lo = '0, pre_hi = '0;
    logic [3:0] cnt_lo, cnt_hi;
    logic       c_lo, b_lo, c_hi, b_hi;
    logic       ld_b_n = 1'b1, up_b = 1'b1, dn_b = 1'b1;
    logic [3:0] pre_b = '0, cnt_b;
    logic       c_b, b_b;

    int checks = 0, errors = 0;
    int model = 0, model_b = 0;
    bit steady = 1'b0;

    dual_clk_updown_ctr u_dual_clk_updown_ctr (
        .clk(clk), .rst(rst), .master_clear(mclr), .load_n(ld_n), .preset(pre_lo),
        .up_clk(up_in), .dn_clk(dn_in), .count(cnt_lo), .carry_n(c_lo), .borrow_n(b_lo));

    dual_clk_updown_ctr u_hi (
        .clk(clk), .rst(rst), .master_clear(mclr), .load_n(ld_n), .preset(pre_hi),
        .up_clk(c_lo), .dn_clk(b_lo), .count(cnt_hi), .carry_n(c_hi), .borrow_n(b_hi));

    dual_clk_updown_ctr #(.DECADE(1'b0)) u_bin (
        .clk(clk), .rst(rst), .master_clear(mclr), .load_n(ld_b_n), .preset(pre_b),
        .up_clk(up_b), .dn_clk(dn_b), .count(cnt_b), .carry_n(c_b), .borrow_n(b_b));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // reference comparison on every clock while the model is valid
    always @(negedge clk) begin
        #1;
        if (steady && !rst) begin
            chk(cnt_hi * 10 + cnt_lo == model, "R11 two-digit value", cnt_hi * 10 + cnt_lo, model);
            chk(int'(cnt_b) == model_b, "R5 binary value", cnt_b, model_b);
        end
    end

    task automatic up_c();
        steady = 1'b0;
        up_in = 1'b0;
        settle(5); #1;
        chk(c_lo == ((model % 10 == 9) ? 1'b0 : 1'b1), "R7 carry during up low", c_lo, (model % 10 == 9) ? 0 : 1);
        up_in = 1'b1;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk); #1;
            if (model % 10 == 9) begin
                if (cnt_lo == 4'd9) chk(c_lo == 1'b0, "R7 carry held until wrap", c_lo, 0);
                else                chk(c_lo == 1'b1, "R7 carry released at zero", c_lo, 1);
            end
        end
        model = (model + 1) % 100;
        steady = 1'b1;
        settle(2);
    endtask

    task automatic dn_c();
        steady = 1'b0;
        dn_in = 1'b0;
        settle(5); #1;
        chk(b_lo == ((model % 10 == 0) ? 1'b0 : 1'b1), "R8 borrow during down low", b_lo, (model % 10 == 0) ? 0 : 1);
        dn_in = 1'b1;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk); #1;
            if (model % 10 == 0) begin
                if (cnt_lo == 4'd0) chk(b_lo == 1'b0, "R8 borrow held until wrap", b_lo, 0);
                else                chk(b_lo == 1'b1, "R8 borrow released at max", b_lo, 1);
            end
        end
        model = (model + 99) % 100;
        steady = 1'b1;
        settle(2);
    endtask

    task automatic load_c(input int v);
        steady = 1'b0;
        pre_hi = 4'(v / 10);
        pre_lo = 4'(v % 10);
        ld_n = 1'b0;
        settle(2);
        ld_n = 1'b1;
        settle(6); #1;
        chk(cnt_hi * 10 + cnt_lo == v, "R2 parallel load", cnt_hi * 10 + cnt_lo, v);
        model = v;
        steady = 1'b1;
        settle(1);
    endtask

    task automatic up_bin();
        steady = 1'b0;
        up_b = 1'b0;
        settle(5); #1;
        chk(c_b == ((model_b == 15) ? 1'b0 : 1'b1), "R7 binary carry", c_b, (model_b == 15) ? 0 : 1);
        up_b = 1'b1;
        settle(10);
        model_b = (model_b + 1) % 16;
        steady = 1'b1;
        settle(2);
    endtask

    task automatic dn_bin();
        steady = 1'b0;
        dn_b = 1'b0;
        settle(5); #1;
        chk(b_b == ((model_b == 0) ? 1'b0 : 1'b1), "R8 binary borrow", b_b, (model_b == 0) ? 0 : 1);
        dn_b = 1'b1;
        settle(10);
        model_b = (model_b + 15) % 16;
        steady = 1'b1;
        settle(2);
    endtask

    initial begin
        #2_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual 0 expected 1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        settle(4);
        rst = 1'b0;
        settle(2); #1;
        chk(cnt_lo == 0 && cnt_hi == 0, "R1 reset count", cnt_hi * 10 + cnt_lo, 0);
        chk(c_lo == 1'b1 && b_lo == 1'b1, "R1 reset terminals idle", {c_lo, b_lo}, 3);
        steady = 1'b1;

        // R3 R11: count up across the digit boundary
        for (int i = 0; i < 12; i++) up_c();
        // R2 then R5: wrap 99 -> 00 upward
        load_c(97);
        for (int i = 0; i < 5; i++) up_c();
        // R4 R8 R5: wrap 00 -> 99 downward
        for (int i = 0; i < 4; i++) dn_c();

        // R9: both clocks rise together
        steady = 1'b0;
        up_in = 1'b0; dn_in = 1'b0;
        settle(6);
        up_in = 1'b1; dn_in = 1'b1;
        settle(10); #1;
        chk(cnt_hi * 10 + cnt_lo == model, "R9 simultaneous rise ignored", cnt_hi * 10 + cnt_lo, model);
        // R9: up rises while down is low, then down rises with up high
        dn_in = 1'b0;
        settle(6);
        up_in = 1'b0;
        settle(6);
        up_in = 1'b1;
        settle(10); #1;
        chk(cnt_hi * 10 + cnt_lo == model, "R9 up edge with down low ignored", cnt_hi * 10 + cnt_lo, model);
        dn_in = 1'b1;
        settle(10); #1;
        model = (model + 99) % 100;
        chk(cnt_hi * 10 + cnt_lo == model, "R4 down edge with up high", cnt_hi * 10 + cnt_lo, model);
        steady = 1'b1;
        settle(2);

        // R10: edges during load and in the release cycle
        steady = 1'b0;
        pre_hi = 4'd4; pre_lo = 4'd5;
        ld_n = 1'b0; up_in = 1'b0;
        settle(4);
        up_in = 1'b1;
        settle(10); #1;
        chk(cnt_hi * 10 + cnt_lo == 45, "R10 edge during load", cnt_hi * 10 + cnt_lo, 45);
        up_in = 1'b0;
        settle(6);
        up_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        ld_n = 1'b1;
        settle(10); #1;
        chk(cnt_hi * 10 + cnt_lo == 45, "R10 edge at release dropped", cnt_hi * 10 + cnt_lo, 45);
        model = 45;
        steady = 1'b1;
        up_c();

        // R1: clear wins over load
        steady = 1'b0;
        mclr = 1'b1; ld_n = 1'b0;
        settle(3);
        mclr = 1'b0; ld_n = 1'b1;
        settle(4); #1;
        chk(cnt_hi * 10 + cnt_lo == 0, "R1 clear overrides load", cnt_hi * 10 + cnt_lo, 0);
        model = 0;
        model_b = 0;
        steady = 1'b1;
        settle(2);

        // R6: illegal decade states recover in one step
        steady = 1'b0;
        pre_hi = 4'd3; pre_lo = 4'd12;
        ld_n = 1'b0; settle(2); ld_n = 1'b1;
        settle(4); #1;
        chk(cnt_lo == 4'd12, "R6 illegal preset taken", cnt_lo, 12);
        up_in = 1'b0;
        settle(5); #1;
        chk(c_lo == 1'b1, "R7 no carry at illegal value", c_lo, 1);
        up_in = 1'b1;
        settle(10); #1;
        chk(cnt_lo == 0 && cnt_hi == 3, "R6 up from 12 gives 0", cnt_hi * 10 + cnt_lo, 30);
        pre_lo = 4'd13;
        ld_n = 1'b0; settle(2); ld_n = 1'b1;
        settle(4);
        dn_in = 1'b0;
        settle(5); #1;
        chk(b_lo == 1'b1, "R8 no borrow at illegal value", b_lo, 1);
        dn_in = 1'b1;
        settle(10); #1;
        chk(cnt_lo == 9 && cnt_hi == 3, "R6 down from 13 gives 9", cnt_hi * 10 + cnt_lo, 39);
        model = 39;
        steady = 1'b1;
        settle(2);

        // R5: binary range 15 <-> 0
        steady = 1'b0;
        pre_b = 4'd14;
        ld_b_n = 1'b0; settle(2); ld_b_n = 1'b1;
        settle(4); #1;
        chk(cnt_b == 4'd14, "R2 binary load", cnt_b, 14);
        model_b = 14;
        steady = 1'b1;
        up_bin();
        up_bin();
        chk(cnt_b == 4'd0, "R5 binary wrap up", cnt_b, 0);
        dn_bin();
        chk(cnt_b == 4'd15, "R5 binary wrap down", cnt_b, 15);
        dn_bin();

        steady = 1'b0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule